// File: doc/BRIEF.md
# Video Chip CPU Register Port

This block is the processor-facing side of a tile-based video chip. It decodes a byte-wide register window and holds the control, mask and scroll values that the rendering logic reads. It also keeps the 14-bit video memory pointer that the processor uses to reach video memory. There are eight registers. Only the three lowest address bits select a register, so the set of eight repeats every eight bytes across the whole window. Register index 0 is control, 1 is mask, 2 is status, 3 and 4 belong to the sprite memory port (not stored here), 5 is scroll, 6 is the pointer and 7 is the data port.

The scroll and pointer registers both take two writes. They share a single first/second toggle, and a status read resets that toggle. Data-port reads below the palette region come back one access late through a read buffer. Reads inside the palette region return at once from a small on-chip palette memory. The buffer is still refilled in that case, from the location 0x1000 below. Each data access that reaches video memory sends a one-cycle request to the external memory with the address as it was before the access. The pointer then moves on by 1 or by 32. The status flags come in from a separate timing unit. A pulse on `stat_rd` tells that unit when a status read has happened.

The processor must leave at least two idle cycles between accesses. This gives the buffer time to refill before the next access.

Top module: `vid_regport`

## Requirements
- R1: A register is selected by cpu_addr[2:0] alone. Upper address bits have no effect, so a write at any offset whose low bits are 0 loads `ctrl_q`, and one whose low bits are 1 loads `mask_q`.
- R2: After reset, `cpu_rdata`, `ctrl_q`, `mask_q`, `scroll_x`, `scroll_y`, `stat_rd`, `vram_req` and the read buffer are 0, and the shared toggle is in the first-write state.
- R3: The pointer register (index 6) takes the high byte first, then the low byte. Bits 7:6 of the high byte are dropped, so the pointer is 14 bits wide and larger values fold down. The second write loads the whole pointer in one cycle.
- R4: Scroll (index 5) and pointer writes share one toggle, which flips on every write to either register. A scroll write in the first state loads `scroll_x`, and one in the second state loads `scroll_y`. Both are full 8-bit values.
- R5: A status read (index 2) returns {vblank_flag, spr0_flag, ovf_flag, bits 4:0 of the last written byte}. It resets the shared toggle and raises `stat_rd` for one cycle.
- R6: After each data-port access, the pointer advances by 1 when ctrl bit 2 is 0 and by 32 when ctrl bit 2 is 1. It wraps modulo 2^14.
- R7: A data read with the pointer below 0x3F00 returns the old buffer contents. It then refills the buffer from the external memory at the pre-increment pointer.
- R8: A data read with the pointer at 0x3F00 or above returns palette entry pointer[4:0] directly. It still refills the buffer, from external address pointer minus 0x1000.
- R9: While mask bit 0 is 1, palette values read through the data port are ANDed with 0x30. Palette writes are stored unmasked.
- R10: A data write below 0x3F00 sends a request with `vram_we`=1, the pre-increment pointer and the written byte. A data write at 0x3F00 or above goes only to the palette and sends no external request.
- R11: A read of any register other than status or data returns the last byte written to the port. `ctrl_q` and `mask_q` hold their values until their own register is written.
- R12: `cpu_rdata` and any `vram_req` appear in the cycle after the access. `vram_req` lasts exactly one cycle, and external read data is taken in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cs | input | 1 | Register access strobe, one cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | CPU_AW | Offset in the register window |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid the cycle after a read |
| vblank_flag | input | 1 | Vertical blank flag from the timing unit |
| spr0_flag | input | 1 | Sprite-zero hit flag from the timing unit |
| ovf_flag | input | 1 | Sprite overflow flag from the timing unit |
| stat_rd | output | 1 | One-cycle pulse after a status read |
| ctrl_q | output | DW | Control register |
| mask_q | output | DW | Mask register |
| scroll_x | output | DW | Horizontal scroll value |
| scroll_y | output | DW | Vertical scroll value |
| vram_req | output | 1 | External memory request, one cycle |
| vram_we | output | 1 | Request is a write |
| vram_addr | output | VAW | Request address |
| vram_wdata | output | DW | Request write data |
| vram_rdata | input | DW | External read data, valid the cycle after the request |

## Verification
The hardest case to reach is the shared toggle left half-way by a scroll write, so that the next pointer write is taken as the low byte. The stimulus writes scroll once and then writes the pointer once. It then shows that the pointer was loaded by reading the data port twice and checking the location that comes back. Palette reads are followed by a move to a low address and one more read. This brings the hidden buffer refill (from 0x1000 below) out through the normal data port. A reference model in the bench compares every output on every clock.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  localparam int REG_SEL_W = 3;

  typedef enum logic [REG_SEL_W-1:0] {
    RI_CTRL = 3'd0,
    RI_MASK = 3'd1,
    RI_STAT = 3'd2,
    RI_OADR = 3'd3,
    RI_ODAT = 3'd4,
    RI_SCRL = 3'd5,
    RI_ADDR = 3'd6,
    RI_DATA = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_mask;
    logic rd_stat;
    logic wr_scrl;
    logic wr_addr;
    logic wr_data;
    logic rd_data;
    logic wr_any;
    logic rd_other;
  } port_strb_t;
endpackage

// File: rtl/vrp_decode.sv
module vrp_decode
  import vrp_pkg::*;
#(
  parameter int CPU_AW = 13
) (
  input  logic              cs,
  input  logic              wr,
  input  logic [CPU_AW-1:0] addr,
  output port_strb_t        strb
);
  localparam int NREG = 1 << REG_SEL_W;
  localparam logic [NREG-1:0] OTHER_RD = 8'b0111_1011;

  logic [NREG-1:0] hit;
  logic            unused_hi;

  // Upper address bits are ignored, so the window mirrors every 8 bytes.
  assign unused_hi = ^addr[CPU_AW-1:REG_SEL_W];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_sel
    assign hit[gi] = cs && (addr[REG_SEL_W-1:0] == REG_SEL_W'(gi));
  end

  always_comb begin
    strb.wr_ctrl  = hit[RI_CTRL] & wr;
    strb.wr_mask  = hit[RI_MASK] & wr;
    strb.rd_stat  = hit[RI_STAT] & ~wr;
    strb.wr_scrl  = hit[RI_SCRL] & wr;
    strb.wr_addr  = hit[RI_ADDR] & wr;
    strb.wr_data  = hit[RI_DATA] & wr;
    strb.rd_data  = hit[RI_DATA] & ~wr;
    strb.wr_any   = cs & wr;
    strb.rd_other = (|(hit & OTHER_RD)) & ~wr;
  end
endmodule

// File: rtl/vrp_addr_ctl.sv
module vrp_addr_ctl #(
  parameter int VAW      = 14,
  parameter int DW       = 8,
  parameter int ROW_STEP = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_stat,
  input  logic           wr_scrl,
  input  logic           wr_addr,
  input  logic [DW-1:0]  wdata,
  input  logic           step,
  input  logic           big_step,
  output logic [VAW-1:0] vaddr,
  output logic           tog,
  output logic [DW-1:0]  sx,
  output logic [DW-1:0]  sy
);
  localparam int HI_W = VAW - DW;

  logic [HI_W-1:0] hi_q;
  logic [VAW-1:0]  stride;

  assign stride = big_step ? VAW'(ROW_STEP) : VAW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tog   <= 1'b0;
      hi_q  <= '0;
      vaddr <= '0;
      sx    <= '0;
      sy    <= '0;
    end else begin
      if (rd_stat)
        tog <= 1'b0;
      else if (wr_scrl || wr_addr)
        tog <= ~tog;

      if (wr_scrl && !tog) sx <= wdata;
      if (wr_scrl && tog)  sy <= wdata;

      // High byte: bits above the 14-bit space are dropped (fold down).
      if (wr_addr && !tog) hi_q <= wdata[HI_W-1:0];

      if (wr_addr && tog)
        vaddr <= {hi_q, wdata};
      else if (step)
        vaddr <= vaddr + stride;
    end
  end
endmodule

// File: rtl/vrp_dataport.sv
module vrp_dataport #(
  parameter int              VAW        = 14,
  parameter int              DW         = 8,
  parameter int              PAL_DEPTH  = 32,
  parameter logic [VAW-1:0]  PAL_BASE   = 14'h3F00,
  parameter logic [VAW-1:0]  SHADOW_OFS = 14'h1000,
  parameter logic [DW-1:0]   GREY_MASK  = 8'h30
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_data,
  input  logic           wr_data,
  input  logic [DW-1:0]  wdata,
  input  logic [VAW-1:0] vaddr,
  input  logic           grey,
  input  logic [DW-1:0]  vram_rdata,
  output logic           vram_req,
  output logic           vram_we,
  output logic [VAW-1:0] vram_addr,
  output logic [DW-1:0]  vram_wdata,
  output logic           step,
  output logic [DW-1:0]  rd_val
);
  localparam int PAL_AW = $clog2(PAL_DEPTH);

  logic [DW-1:0]     pal_mem [PAL_DEPTH];
  logic [DW-1:0]     pal_rd;
  logic [DW-1:0]     rbuf;
  logic              pal_hit;
  logic              fill1, fill2;
  logic [PAL_AW-1:0] pidx;

  assign pal_hit = (vaddr >= PAL_BASE);
  assign pidx    = vaddr[PAL_AW-1:0];
  assign pal_rd  = pal_mem[pidx];

  // Small palette RAM: write-only port plus an asynchronous read.
  always_ff @(posedge clk) begin
    if (wr_data && pal_hit) pal_mem[pidx] <= wdata;
  end

  always_comb begin
    if (pal_hit)
      rd_val = grey ? (pal_rd & GREY_MASK) : pal_rd;
    else
      rd_val = rbuf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vram_req   <= 1'b0;
      vram_we    <= 1'b0;
      vram_addr  <= '0;
      vram_wdata <= '0;
      step       <= 1'b0;
      fill1      <= 1'b0;
      fill2      <= 1'b0;
      rbuf       <= '0;
    end else begin
      vram_req <= rd_data | (wr_data & ~pal_hit);
      vram_we  <= wr_data & ~pal_hit;
      step     <= rd_data | wr_data;
      fill1    <= rd_data;
      fill2    <= fill1;
      if (rd_data)
        vram_addr <= pal_hit ? (vaddr - SHADOW_OFS) : vaddr;
      else if (wr_data)
        vram_addr <= vaddr;
      if (wr_data) vram_wdata <= wdata;
      if (fill2) rbuf <= vram_rdata;
    end
  end
endmodule

// File: rtl/vid_regport.sv
module vid_regport
  import vrp_pkg::*;
#(
  parameter int CPU_AW    = 13,
  parameter int DW        = 8,
  parameter int VAW       = 14,
  parameter int PAL_DEPTH = 32,
  parameter int ROW_STEP  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_cs,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  input  logic              vblank_flag,
  input  logic              spr0_flag,
  input  logic              ovf_flag,
  output logic              stat_rd,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     mask_q,
  output logic [DW-1:0]     scroll_x,
  output logic [DW-1:0]     scroll_y,
  output logic              vram_req,
  output logic              vram_we,
  output logic [VAW-1:0]    vram_addr,
  output logic [DW-1:0]     vram_wdata,
  input  logic [DW-1:0]     vram_rdata
);
  localparam int INC_BIT  = 2;
  localparam int GREY_BIT = 0;
  localparam int LAT_W    = DW - 3;

  port_strb_t     strb;
  logic [VAW-1:0] vaddr;
  logic           wtog;
  logic           step;
  logic [DW-1:0]  rd_val;
  logic [DW-1:0]  latch_q;

  vrp_decode #(.CPU_AW(CPU_AW)) u_dec (
    .cs   (cpu_cs),
    .wr   (cpu_wr),
    .addr (cpu_addr),
    .strb (strb)
  );

  vrp_addr_ctl #(.VAW(VAW), .DW(DW), .ROW_STEP(ROW_STEP)) u_actl (
    .clk      (clk),
    .rst      (rst),
    .rd_stat  (strb.rd_stat),
    .wr_scrl  (strb.wr_scrl),
    .wr_addr  (strb.wr_addr),
    .wdata    (cpu_wdata),
    .step     (step),
    .big_step (ctrl_q[INC_BIT]),
    .vaddr    (vaddr),
    .tog      (wtog),
    .sx       (scroll_x),
    .sy       (scroll_y)
  );

  vrp_dataport #(.VAW(VAW), .DW(DW), .PAL_DEPTH(PAL_DEPTH)) u_dport (
    .clk        (clk),
    .rst        (rst),
    .rd_data    (strb.rd_data),
    .wr_data    (strb.wr_data),
    .wdata      (cpu_wdata),
    .vaddr      (vaddr),
    .grey       (mask_q[GREY_BIT]),
    .vram_rdata (vram_rdata),
    .vram_req   (vram_req),
    .vram_we    (vram_we),
    .vram_addr  (vram_addr),
    .vram_wdata (vram_wdata),
    .step       (step),
    .rd_val     (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mask_q    <= '0;
      latch_q   <= '0;
      cpu_rdata <= '0;
      stat_rd   <= 1'b0;
    end else begin
      stat_rd <= strb.rd_stat;
      if (strb.wr_any)  latch_q <= cpu_wdata;
      if (strb.wr_ctrl) ctrl_q  <= cpu_wdata;
      if (strb.wr_mask) mask_q  <= cpu_wdata;
      if (strb.rd_stat)
        cpu_rdata <= {vblank_flag, spr0_flag, ovf_flag, latch_q[LAT_W-1:0]};
      else if (strb.rd_data)
        cpu_rdata <= rd_val;
      else if (strb.rd_other)
        cpu_rdata <= latch_q;
    end
  end
endmodule

// File: rtl/vid_regport_chk.sv
module vid_regport_chk #(
  parameter int DW  = 8,
  parameter int VAW = 14
) (
  input logic           clk,
  input logic           rst,
  input logic           cpu_cs,
  input logic           cpu_wr,
  input logic [2:0]     idx,
  input logic           vram_req,
  input logic           stat_rd,
  input logic [DW-1:0]  cpu_rdata,
  input logic [DW-1:0]  ctrl_q,
  input logic           grey,
  input logic           wtog,
  input logic [VAW-1:0] vaddr
);
  localparam logic [VAW-1:0] PAL_LO = 14'h3F00;

  // R12: requests last exactly one cycle
  p_req_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    vram_req |=> !vram_req);

  // R12: a request only follows a data-port access
  p_req_source_r12: assert property (@(posedge clk) disable iff (rst)
    vram_req |-> $past(cpu_cs && idx == 3'd7));

  // R5: status pulse follows a status read, and the toggle is back in the first state
  p_stat_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    stat_rd |-> ($past(cpu_cs && !cpu_wr && idx == 3'd2) && !wtog));

  // R9: greyscale palette read leaves only bits 5:4
  p_grey_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_cs && !cpu_wr && idx == 3'd7 && vaddr >= PAL_LO && grey)
      |=> ((cpu_rdata & 8'hCF) == 8'h00));

  // R10: palette-region writes stay on chip
  p_pal_wr_local_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_cs && cpu_wr && idx == 3'd7 && vaddr >= PAL_LO) |=> !vram_req);

  // R11: control register holds unless written
  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(cpu_cs && cpu_wr && idx == 3'd0) |=> $stable(ctrl_q));
endmodule

bind vid_regport vid_regport_chk #(.DW(DW), .VAW(VAW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_cs    (cpu_cs),
  .cpu_wr    (cpu_wr),
  .idx       (cpu_addr[2:0]),
  .vram_req  (vram_req),
  .stat_rd   (stat_rd),
  .cpu_rdata (cpu_rdata),
  .ctrl_q    (ctrl_q),
  .grey      (mask_q[0]),
  .wtog      (wtog),
  .vaddr     (vaddr)
);

// File: tb/test_vid_regport.sv
module test_vid_regport;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_cs = 1'b0, cpu_wr = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        vblank_flag = 1'b0, spr0_flag = 1'b0, ovf_flag = 1'b0;
  logic        stat_rd;
  logic [7:0]  ctrl_q, mask_q, scroll_x, scroll_y;
  logic        vram_req, vram_we;
  logic [13:0] vram_addr;
  logic [7:0]  vram_wdata;
  logic [7:0]  vram_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  vid_regport i_vid_regport (
    .clk(clk), .rst(rst), .cpu_cs(cpu_cs), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vblank_flag(vblank_flag),
    .spr0_flag(spr0_flag), .ovf_flag(ovf_flag), .stat_rd(stat_rd),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .scroll_x(scroll_x), .scroll_y(scroll_y),
    .vram_req(vram_req), .vram_we(vram_we), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata), .vram_rdata(vram_rdata)
  );

  // External video memory: sparse, unwritten locations hold a hash.
  logic [7:0] store [int];

  function automatic logic [7:0] hash(input int a);
    return 8'(((a * 7) + 3) ^ (a >> 8));
  endfunction

  function automatic logic [7:0] mem_val(input int a);
    if (store.exists(a)) return store[a];
    return hash(a);
  endfunction

  always @(posedge clk) begin
    if (vram_req && vram_we) store[int'(vram_addr)] = vram_wdata;
    else if (vram_req) vram_rdata <= mem_val(int'(vram_addr));
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", rq, act, exp, cycles);
    end
  endtask

  // Behavioural reference model
  int   m_tog, m_hi, m_vaddr, m_buf, m_latch;
  int   m_pal [32];
  int   e_ctrl, e_mask, e_sx, e_sy, e_rdata, e_req, e_we, e_addr, e_wdata, e_stat;

  always @(posedge clk) begin
    if (rst) begin
      m_tog = 0; m_hi = 0; m_vaddr = 0; m_buf = 0; m_latch = 0;
      e_ctrl = 0; e_mask = 0; e_sx = 0; e_sy = 0; e_rdata = 0;
      e_req = 0; e_we = 0; e_addr = 0; e_wdata = 0; e_stat = 0;
    end else begin
      int idx;
      int pal;
      int nxt;
      e_req = 0; e_we = 0; e_stat = 0;
      if (cpu_cs) begin
        idx = int'(cpu_addr[2:0]);
        pal = (m_vaddr >= 'h3F00) ? 1 : 0;
        nxt = (m_vaddr + ((e_ctrl & 4) != 0 ? 32 : 1)) % 16384;
        if (cpu_wr) begin
          m_latch = int'(cpu_wdata);
          case (idx)
            0: e_ctrl = int'(cpu_wdata);
            1: e_mask = int'(cpu_wdata);
            5: begin
              if (m_tog == 0) e_sx = int'(cpu_wdata); else e_sy = int'(cpu_wdata);
              m_tog = 1 - m_tog;
            end
            6: begin
              if (m_tog == 0) m_hi = int'(cpu_wdata) % 64;
              else m_vaddr = m_hi * 256 + int'(cpu_wdata);
              m_tog = 1 - m_tog;
            end
            7: begin
              if (pal == 1) m_pal[m_vaddr % 32] = int'(cpu_wdata);
              else begin
                e_req = 1; e_we = 1; e_addr = m_vaddr; e_wdata = int'(cpu_wdata);
              end
              m_vaddr = nxt;
            end
            default: ;
          endcase
        end else begin
          case (idx)
            2: begin
              e_rdata = (vblank_flag ? 128 : 0) + (spr0_flag ? 64 : 0) +
                        (ovf_flag ? 32 : 0) + (m_latch % 32);
              m_tog = 0; e_stat = 1;
            end
            7: begin
              e_req = 1;
              if (pal == 1) begin
                e_rdata = m_pal[m_vaddr % 32];
                if ((e_mask & 1) != 0) e_rdata = e_rdata & 'h30;
                e_addr = m_vaddr - 'h1000;
              end else begin
                e_rdata = m_buf;
                e_addr = m_vaddr;
              end
              m_buf = int'(mem_val(e_addr));
              m_vaddr = nxt;
            end
            default: e_rdata = m_latch;
          endcase
        end
      end
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      chk("R11 ctrl", int'(ctrl_q), e_ctrl);
      chk("R11 mask", int'(mask_q), e_mask);
      chk("R4 scroll_x", int'(scroll_x), e_sx);
      chk("R4 scroll_y", int'(scroll_y), e_sy);
      chk("R5 stat_rd", int'(stat_rd), e_stat);
      chk("R12 vram_req", int'(vram_req), e_req);
      chk("R7 cpu_rdata", int'(cpu_rdata), e_rdata);
      if (vram_req) begin
        chk("R10 vram_we", int'(vram_we), e_we);
        chk("R6 vram_addr", int'(vram_addr), e_addr);
        if (vram_we) chk("R10 vram_wdata", int'(vram_wdata), e_wdata);
      end
      if (cycles > 20000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  function automatic logic [12:0] adr(input int idx, input int hi);
    return {10'(hi), 3'(idx)};
  endfunction

  task automatic wr(input int idx, input int d, input int hi = 0);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_wr = 1'b1; cpu_addr = adr(idx, hi); cpu_wdata = 8'(d);
    @(negedge clk);
    cpu_cs = 1'b0; cpu_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input int idx, output int d, input int hi = 0);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_wr = 1'b0; cpu_addr = adr(idx, hi);
    @(negedge clk);
    cpu_cs = 1'b0;
    d = int'(cpu_rdata);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_ptr(input int a);
    int dummy;
    rd(2, dummy);
    wr(6, a / 256);
    wr(6, a % 256);
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    chk("R2 rdata", int'(cpu_rdata), 0);
    chk("R2 ctrl", int'(ctrl_q), 0);
    chk("R2 req", int'(vram_req), 0);

    // R1: mirrored decode
    wr(0, 'h80, 'h2A5);
    chk("R1 ctrl via mirror", int'(ctrl_q), 'h80);
    wr(1, 'h1E, 'h3FF);
    chk("R1 mask via mirror", int'(mask_q), 'h1E);

    // R5 / R11: status and latch
    wr(3, 'h5A);
    vblank_flag = 1'b1; spr0_flag = 1'b1;
    rd(2, d, 'h111);
    chk("R5 status byte", d, 'hDA);
    vblank_flag = 1'b0; spr0_flag = 1'b0; ovf_flag = 1'b1;
    rd(2, d);
    chk("R5 status ovf", d, 'h3A);
    ovf_flag = 1'b0;
    rd(3, d, 'h040);
    chk("R11 latch readback", d, 'h5A);

    // R3 / R7: pointer load with fold, buffered reads
    wr(0, 'h00);
    wr(6, 'hE1);
    wr(6, 'h08);
    rd(7, d);
    chk("R7 first read gives reset buffer", d, 0);
    rd(7, d);
    chk("R3 folded pointer 0x2108", d, int'(hash('h2108)));

    // R6: step of 32
    wr(0, 'h04);
    rd(7, d);
    chk("R7 delayed data", d, int'(hash('h2109)));
    rd(7, d);
    chk("R6 step 1 before switch", d, int'(hash('h210A)));
    rd(7, d);
    chk("R6 step 32", d, int'(hash('h212A)));

    // R4: half-written toggle shared between scroll and pointer
    wr(0, 'h00);
    rd(2, d);
    wr(5, 'h33);
    wr(6, 'h77);
    chk("R4 scroll_x from first write", int'(scroll_x), 'h33);
    chk("R4 scroll_y untouched", int'(scroll_y), 0);
    rd(7, d);
    rd(7, d);
    chk("R4 pointer low byte via toggle", d, int'(hash('h2177)));
    rd(2, d);
    wr(5, 'h44);
    wr(5, 'h55);
    chk("R4 scroll_x", int'(scroll_x), 'h44);
    chk("R4 scroll_y", int'(scroll_y), 'h55);

    // R10: write below palette and read back
    set_ptr('h0140);
    wr(7, 'hA5);
    set_ptr('h0140);
    rd(7, d);
    rd(7, d);
    chk("R10 written byte", d, 'hA5);

    // R8: palette write then immediate read, buffer shadow refill
    set_ptr('h3F05);
    wr(7, 'h2D);
    set_ptr('h3F05);
    rd(7, d);
    chk("R8 palette direct", d, 'h2D);
    set_ptr('h0000);
    rd(7, d);
    chk("R8 shadow refill", d, int'(hash('h2F05)));

    // R9: greyscale masking on reads, not on writes
    wr(1, 'h01);
    set_ptr('h3F05);
    rd(7, d);
    chk("R9 grey read", d, 'h20);
    wr(7, 'h1B);
    wr(1, 'h00);
    set_ptr('h3F06);
    rd(7, d);
    chk("R9 unmasked write", d, 'h1B);

    // R6: wrap at the top of the 14-bit space
    set_ptr('h3FFF);
    wr(7, 'h11);
    rd(7, d);
    rd(7, d);
    chk("R6 wrap to 0", d, int'(hash('h0000)));

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule